// File: doc/BRIEF.md
# Write Request Chunk Splitter

The block accepts one long write request (byte address, byte length) and turns it into a series of sub-requests for two downstream program engines. One engine programs single words. The other programs a whole write buffer. The upper address bits select a chip and the lower bits give the offset inside that chip.

When the offset is not aligned to the data-bus width, the leading bytes up to the next bus-width boundary go first to the single-word engine. Every later chunk goes to the buffered engine. Each buffered chunk is cut so that it ends at or before the next write-buffer boundary. The buffer size is the interleave factor scaled by a power of two that the device reports.

When a chunk ends exactly at the end of a chip, the walk moves on to offset zero of the next chip. Once it runs past the last chip, the request stops with success. The block issues one sub-request at a time and waits for the engine to report completion before it issues the next. A reported error aborts the rest of the request. The final status returns the error code and the count of bytes that completed.

Top module: `wreq_splitter`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `sub_valid_o`, `done_o`, `err_o` and `bytes_o` are 0.
- R2: A request is completed with `done_o` one cycle after acceptance, with `bytes_o` 0, `err_o` 0 and no sub-request, when either its length is zero or its chip index is at or above NUM_CHIPS.
- R3: The chip index of a request is `req_addr_i >> CHIP_SHIFT`. The in-chip offset is the low CHIP_SHIFT address bits. Each sub-request carries both values on `sub_chip_o` and `sub_ofs_o`.
- R4: When the offset is not a multiple of 2^BUS_LOG2, the first sub-request has `sub_word_path_o` = 1. Its size is (−offset) mod 2^BUS_LOG2, limited to the remaining length.
- R5: Every other sub-request has `sub_word_path_o` = 0. Its size is B − (offset mod B), limited to the remaining length, where B = 2^(INTLV_LOG2 + `req_buf_log2_i`) as sampled at acceptance.
- R6: When an offset plus a completed chunk size equals 2^CHIP_SHIFT, the next sub-request uses chip index + 1 and offset 0.
- R7: When that chip step would reach NUM_CHIPS, the request ends with success, even if bytes remain. `bytes_o` then holds the bytes completed so far.
- R8: At most one sub-request is outstanding. `sub_valid_o` drops in the cycle after the handshake, and it rises again only after `sub_done_i`. While `sub_valid_o` is high and `sub_ready_i` is low, all sub-request fields hold steady.
- R9: If `sub_done_i` arrives with `sub_err_i` = 1, no further sub-request is issued. `done_o` then reports `err_o` = 1, the code given on `sub_err_code_i`, and the bytes of the earlier successful chunks.
- R10: On success, `bytes_o` at `done_o` equals the sum of all completed chunk sizes. This is the full length unless R7 applies.
- R11: `req_ready_o` is 0 from acceptance until `done_o` has been shown. A `req_valid_i` in that time is ignored.
- R12: `done_o` is a one-cycle pulse. It appears in the cycle after the `sub_done_i` of the last chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request present |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_len_i | input | LEN_W | Byte length of the request |
| req_buf_log2_i | input | BL_W | Device-reported log2 of buffer size |
| sub_valid_o | output | 1 | Sub-request present |
| sub_ready_i | input | 1 | Engine takes the sub-request |
| sub_chip_o | output | ADDR_W-CHIP_SHIFT | Chip index of the chunk |
| sub_ofs_o | output | CHIP_SHIFT | In-chip byte offset of the chunk |
| sub_size_o | output | LEN_W | Chunk size in bytes |
| sub_word_path_o | output | 1 | 1 = single-word engine, 0 = buffered engine |
| sub_done_i | input | 1 | Engine finished the outstanding chunk |
| sub_err_i | input | 1 | Finished chunk failed |
| sub_err_code_i | input | ERR_W | Error code of the failed chunk |
| done_o | output | 1 | Request finished (one cycle) |
| err_o | output | 1 | Request ended in error |
| err_code_o | output | ERR_W | Error code returned |
| bytes_o | output | LEN_W | Bytes completed |

## Verification
Each result has a fixed latency, counted from the clock edge that carries its cause:

| Stimulus | Result | Latency |
|---|---|---|
| Request accepted | First sub-request | One edge |
| Request accepted (empty or out-of-range) | `done_o` | One edge |
| Handshake on a sub-request | `sub_valid_o` drops | One edge |
| `sub_done_i` of a non-final chunk | Next sub-request | One edge |
| `sub_done_i` of the final chunk | `done_o` with status | One edge |

The bench drives inputs and samples outputs on the falling edge. Each check is placed at the falling edge that follows the causing rising edge. Stalls are held for several cycles to confirm that the fields stay steady, and a request raised while busy is checked for its lack of effect on the chunks that follow.

// File: rtl/wreq_splitter_pkg.sv
`timescale 1ns/1ps
package wreq_splitter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/wreq_chunk_calc.sv
`timescale 1ns/1ps
// Size and engine choice for the chunk starting at the current position.
module wreq_chunk_calc #(
  parameter int OFS_W      = 20,
  parameter int LEN_W      = 16,
  parameter int BUS_LOG2   = 2,
  parameter int INTLV_LOG2 = 0,
  parameter int BL_W       = 4
) (
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [LEN_W-1:0] rem_i,
  input  logic [BL_W-1:0]  buf_log2_i,
  output logic [LEN_W-1:0] size_o,
  output logic             word_path_o
);
  localparam int SZ_W = ((OFS_W > LEN_W) ? OFS_W : LEN_W) + 1;

  logic            head_need;
  logic [SZ_W-1:0] head_sz;
  logic [BL_W:0]   sh;
  logic [SZ_W-1:0] buf_sz, in_buf, span, raw, rem_w;

  generate
    if (BUS_LOG2 > 0) begin : g_head
      logic [BUS_LOG2-1:0] lo, neg;
      assign lo        = ofs_i[BUS_LOG2-1:0];
      assign neg       = ~lo + 1'b1;
      assign head_need = |lo;
      assign head_sz   = SZ_W'(neg);
    end else begin : g_nohead
      assign head_need = 1'b0;
      assign head_sz   = '0;
    end
  endgenerate

  assign sh     = (BL_W+1)'(INTLV_LOG2) + {1'b0, buf_log2_i};
  assign buf_sz = SZ_W'(1) << sh;
  assign in_buf = SZ_W'(ofs_i) & (buf_sz - SZ_W'(1));
  assign span   = buf_sz - in_buf;
  assign raw    = head_need ? head_sz : span;
  assign rem_w  = SZ_W'(rem_i);

  always_comb begin
    if (raw > rem_w) size_o = rem_i;
    else             size_o = raw[LEN_W-1:0];
  end
  assign word_path_o = head_need;
endmodule

// File: rtl/wreq_pos_track.sv
`timescale 1ns/1ps
// Walk position: chip, in-chip offset, bytes left, bytes done.
module wreq_pos_track #(
  parameter int CHIP_W    = 4,
  parameter int OFS_W     = 20,
  parameter int LEN_W     = 16,
  parameter int NUM_CHIPS = 4,
  parameter int BL_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CHIP_W-1:0] ld_chip_i,
  input  logic [OFS_W-1:0]  ld_ofs_i,
  input  logic [LEN_W-1:0]  ld_len_i,
  input  logic [BL_W-1:0]   ld_buf_log2_i,
  input  logic              adv_i,
  input  logic [LEN_W-1:0]  size_i,
  output logic [CHIP_W-1:0] chip_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [LEN_W-1:0]  rem_o,
  output logic [LEN_W-1:0]  bytes_o,
  output logic [BL_W-1:0]   buf_log2_o,
  output logic              fin_o
);
  localparam int AW = ((OFS_W > LEN_W) ? OFS_W : LEN_W) + 1;
  localparam logic [AW-1:0]     CHIP_BYTES = AW'(1) << OFS_W;
  localparam logic [CHIP_W:0]   CHIP_END   = (CHIP_W+1)'(NUM_CHIPS);

  logic [AW-1:0]    ofs_sum;
  logic             wrap, at_end;
  logic [CHIP_W:0]  chip_inc;
  logic [LEN_W-1:0] rem_next;

  assign ofs_sum  = AW'(ofs_o) + AW'(size_i);
  assign wrap     = (ofs_sum >= CHIP_BYTES);
  assign chip_inc = {1'b0, chip_o} + 1'b1;
  assign at_end   = wrap && (chip_inc == CHIP_END);
  assign rem_next = rem_o - size_i;
  assign fin_o    = (rem_next == '0) || at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_o     <= '0;
      ofs_o      <= '0;
      rem_o      <= '0;
      bytes_o    <= '0;
      buf_log2_o <= '0;
    end else if (load_i) begin
      chip_o     <= ld_chip_i;
      ofs_o      <= ld_ofs_i;
      rem_o      <= ld_len_i;
      bytes_o    <= '0;
      buf_log2_o <= ld_buf_log2_i;
    end else if (adv_i) begin
      bytes_o <= bytes_o + size_i;
      rem_o   <= rem_next;
      if (wrap) begin
        chip_o <= chip_inc[CHIP_W-1:0];
        ofs_o  <= '0;
      end else begin
        ofs_o  <= ofs_sum[OFS_W-1:0];
      end
    end
  end
endmodule

// File: rtl/wreq_seq_fsm.sv
`timescale 1ns/1ps
module wreq_seq_fsm
  import wreq_splitter_pkg::*;
#(
  parameter int ERR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_empty_i,
  input  logic             sub_ready_i,
  input  logic             sub_done_i,
  input  logic             sub_err_i,
  input  logic [ERR_W-1:0] sub_err_code_i,
  input  logic             fin_i,
  output logic             req_ready_o,
  output logic             load_o,
  output logic             sub_valid_o,
  output logic             adv_o,
  output logic             done_o,
  output logic             err_o,
  output logic [ERR_W-1:0] err_code_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    adv_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        load_o  = 1'b1;
        state_d = req_empty_i ? ST_FIN : ST_ISSUE;
      end
      ST_ISSUE: if (sub_ready_i) state_d = ST_WAIT;
      ST_WAIT: if (sub_done_i) begin
        if (sub_err_i) state_d = ST_FIN;
        else begin
          adv_o   = 1'b1;
          state_d = fin_i ? ST_FIN : ST_ISSUE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      err_o      <= 1'b0;
      err_code_o <= '0;
    end else begin
      state_q <= state_d;
      if (load_o) begin
        err_o      <= 1'b0;
        err_code_o <= '0;
      end else if (state_q == ST_WAIT && sub_done_i && sub_err_i) begin
        err_o      <= 1'b1;
        err_code_o <= sub_err_code_i;
      end
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign sub_valid_o = (state_q == ST_ISSUE);
  assign done_o      = (state_q == ST_FIN);
endmodule

// File: rtl/wreq_splitter.sv
`timescale 1ns/1ps
module wreq_splitter #(
  parameter int ADDR_W     = 24,
  parameter int CHIP_SHIFT = 20,
  parameter int NUM_CHIPS  = 4,
  parameter int LEN_W      = 16,
  parameter int BUS_LOG2   = 2,
  parameter int INTLV_LOG2 = 0,
  parameter int BL_W       = 4,
  parameter int ERR_W      = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  output logic                         req_ready_o,
  input  logic [ADDR_W-1:0]            req_addr_i,
  input  logic [LEN_W-1:0]             req_len_i,
  input  logic [BL_W-1:0]              req_buf_log2_i,
  output logic                         sub_valid_o,
  input  logic                         sub_ready_i,
  output logic [ADDR_W-CHIP_SHIFT-1:0] sub_chip_o,
  output logic [CHIP_SHIFT-1:0]        sub_ofs_o,
  output logic [LEN_W-1:0]             sub_size_o,
  output logic                         sub_word_path_o,
  input  logic                         sub_done_i,
  input  logic                         sub_err_i,
  input  logic [ERR_W-1:0]             sub_err_code_i,
  output logic                         done_o,
  output logic                         err_o,
  output logic [ERR_W-1:0]             err_code_o,
  output logic [LEN_W-1:0]             bytes_o
);
  localparam int CHIP_W = ADDR_W - CHIP_SHIFT;
  localparam int OFS_W  = CHIP_SHIFT;

  logic [CHIP_W-1:0] ld_chip;
  logic [OFS_W-1:0]  ld_ofs;
  logic              req_empty, load, adv, fin;
  logic [LEN_W-1:0]  rem;
  logic [BL_W-1:0]   buf_log2;

  assign ld_chip   = req_addr_i[ADDR_W-1:CHIP_SHIFT];
  assign ld_ofs    = req_addr_i[CHIP_SHIFT-1:0];
  assign req_empty = (req_len_i == '0) || ((CHIP_W+1)'(ld_chip) >= (CHIP_W+1)'(NUM_CHIPS));

  wreq_pos_track #(
    .CHIP_W(CHIP_W), .OFS_W(OFS_W), .LEN_W(LEN_W), .NUM_CHIPS(NUM_CHIPS), .BL_W(BL_W)
  ) pos_i (
    .clk_i, .rst_ni,
    .load_i(load), .ld_chip_i(ld_chip), .ld_ofs_i(ld_ofs), .ld_len_i(req_len_i),
    .ld_buf_log2_i(req_buf_log2_i), .adv_i(adv), .size_i(sub_size_o),
    .chip_o(sub_chip_o), .ofs_o(sub_ofs_o), .rem_o(rem), .bytes_o(bytes_o),
    .buf_log2_o(buf_log2), .fin_o(fin)
  );

  wreq_chunk_calc #(
    .OFS_W(OFS_W), .LEN_W(LEN_W), .BUS_LOG2(BUS_LOG2), .INTLV_LOG2(INTLV_LOG2), .BL_W(BL_W)
  ) calc_i (
    .ofs_i(sub_ofs_o), .rem_i(rem), .buf_log2_i(buf_log2),
    .size_o(sub_size_o), .word_path_o(sub_word_path_o)
  );

  wreq_seq_fsm #(.ERR_W(ERR_W)) fsm_i (
    .clk_i, .rst_ni,
    .req_valid_i, .req_empty_i(req_empty), .sub_ready_i, .sub_done_i, .sub_err_i,
    .sub_err_code_i, .fin_i(fin),
    .req_ready_o, .load_o(load), .sub_valid_o, .adv_o(adv),
    .done_o, .err_o, .err_code_o
  );
endmodule

// File: rtl/wreq_splitter_chk.sv
`timescale 1ns/1ps
module wreq_splitter_chk #(
  parameter int CHIP_W   = 4,
  parameter int OFS_W    = 20,
  parameter int LEN_W    = 16,
  parameter int BUS_LOG2 = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [LEN_W-1:0]  req_len_i,
  input logic              sub_valid_o,
  input logic              sub_ready_i,
  input logic [CHIP_W-1:0] sub_chip_o,
  input logic [OFS_W-1:0]  sub_ofs_o,
  input logic [LEN_W-1:0]  sub_size_o,
  input logic              sub_word_path_o,
  input logic              done_o,
  input logic [LEN_W-1:0]  bytes_o
);
  localparam logic [LEN_W-1:0] BUS_B = LEN_W'(1) << BUS_LOG2;

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o && !sub_ready_i |=> sub_valid_o && $stable(sub_chip_o) && $stable(sub_ofs_o)
      && $stable(sub_size_o) && $stable(sub_word_path_o));
  // R8
  single_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o && sub_ready_i |=> !sub_valid_o);
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !sub_valid_o && !done_o);
  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  empty_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_len_i == '0 |=> done_o && bytes_o == '0);
  // R4
  head_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o && sub_word_path_o |-> sub_size_o < BUS_B);
  // R5
  nonzero_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_valid_o |-> sub_size_o != '0);
endmodule

bind wreq_splitter wreq_splitter_chk #(
  .CHIP_W(ADDR_W - CHIP_SHIFT), .OFS_W(CHIP_SHIFT), .LEN_W(LEN_W), .BUS_LOG2(BUS_LOG2)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_len_i(req_len_i), .sub_valid_o(sub_valid_o), .sub_ready_i(sub_ready_i),
  .sub_chip_o(sub_chip_o), .sub_ofs_o(sub_ofs_o), .sub_size_o(sub_size_o),
  .sub_word_path_o(sub_word_path_o), .done_o(done_o), .bytes_o(bytes_o)
);

// File: tb/wreq_splitter_tb_top.sv
`timescale 1ns/1ps
module wreq_splitter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic [3:0]  req_bl = '0;
  logic        sub_valid, sub_ready = 1'b0;
  logic [3:0]  sub_chip;
  logic [19:0] sub_ofs;
  logic [15:0] sub_size;
  logic        sub_word;
  logic        sub_done = 1'b0, sub_err = 1'b0;
  logic [3:0]  sub_code = '0;
  logic        done, err;
  logic [3:0]  err_code;
  logic [15:0] bytes;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wreq_splitter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_buf_log2_i(req_bl),
    .sub_valid_o(sub_valid), .sub_ready_i(sub_ready), .sub_chip_o(sub_chip),
    .sub_ofs_o(sub_ofs), .sub_size_o(sub_size), .sub_word_path_o(sub_word),
    .sub_done_i(sub_done), .sub_err_i(sub_err), .sub_err_code_i(sub_code),
    .done_o(done), .err_o(err), .err_code_o(err_code), .bytes_o(bytes)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic start_req(input logic [23:0] a, input logic [15:0] l, input logic [3:0] bl);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = l; req_bl = bl;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 ready low after accept", req_ready, 0);
  endtask

  // One downstream chunk: wait, compare, optional stall, take, finish.
  task automatic do_chunk(input logic [3:0] c, input logic [19:0] o, input logic [15:0] s,
                          input logic w, input int stall, input logic e, input logic [3:0] code);
    bit seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      if (sub_valid) seen = 1;
      else @(negedge clk);
    end
    chk("R8 sub_valid present", sub_valid, 1);
    chk("R3/R6 chip", sub_chip, c);
    chk("R3/R6 offset", sub_ofs, o);
    chk("R4/R5 size", sub_size, s);
    chk("R4/R5 path", sub_word, w);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R8 stall held", {sub_valid, sub_chip, sub_ofs, sub_size, sub_word},
          {1'b1, c, o, s, w});
    end
    sub_ready = 1'b1;
    @(negedge clk);
    sub_ready = 1'b0;
    chk("R8 valid drops after take", sub_valid, 0);
    @(negedge clk);
    chk("R8 no reissue before done", sub_valid, 0);
    sub_done = 1'b1; sub_err = e; sub_code = code;
    @(negedge clk);
    sub_done = 1'b0; sub_err = 1'b0; sub_code = '0;
  endtask

  task automatic check_done(input logic e, input logic [3:0] code, input logic [15:0] b);
    chk("R12 done due", done, 1);
    chk("R9 err flag", err, e);
    chk("R9 err code", err_code, code);
    chk("R10 bytes", bytes, b);
    @(negedge clk);
    chk("R12 done one cycle", done, 0);
    chk("R11 ready again", req_ready, 1);
    chk("R8 no extra chunk", sub_valid, 0);
  endtask

  task automatic t_reset;
    chk("R1 ready", req_ready, 1);
    chk("R1 sub_valid", sub_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 bytes", bytes, 0);
  endtask

  task automatic t_empty;
    start_req(24'h001234, 16'd0, 4'd4);
    chk("R2 zero-length no chunk", sub_valid, 0);
    check_done(1'b0, 4'd0, 16'd0);
    start_req(24'h500000, 16'd8, 4'd4);
    chk("R2 chip out of range no chunk", sub_valid, 0);
    check_done(1'b0, 4'd0, 16'd0);
  endtask

  // Unaligned head, then buffered chunks; stray request while busy.
  task automatic t_head_buffered;
    start_req(24'h000103, 16'd40, 4'd4);
    req_valid = 1'b1; req_addr = 24'h000000; req_len = 16'd4;
    @(negedge clk);
    chk("R11 busy ignores request", req_ready, 0);
    req_valid = 1'b0;
    do_chunk(4'd0, 20'h00103, 16'd1, 1'b1, 0, 1'b0, 4'd0);
    do_chunk(4'd0, 20'h00104, 16'd12, 1'b0, 3, 1'b0, 4'd0);
    do_chunk(4'd0, 20'h00110, 16'd16, 1'b0, 0, 1'b0, 4'd0);
    do_chunk(4'd0, 20'h00120, 16'd11, 1'b0, 0, 1'b0, 4'd0);
    check_done(1'b0, 4'd0, 16'd40);
  endtask

  // R4: head capped by short length.
  task automatic t_head_cap;
    start_req(24'h000021, 16'd2, 4'd4);
    do_chunk(4'd0, 20'h00021, 16'd2, 1'b1, 0, 1'b0, 4'd0);
    check_done(1'b0, 4'd0, 16'd2);
  endtask

  // R6: step into next chip.
  task automatic t_chip_step;
    start_req(24'h0FFFF8, 16'd24, 4'd4);
    do_chunk(4'd0, 20'hFFFF8, 16'd8, 1'b0, 0, 1'b0, 4'd0);
    do_chunk(4'd1, 20'h00000, 16'd16, 1'b0, 0, 1'b0, 4'd0);
    check_done(1'b0, 4'd0, 16'd24);
  endtask

  // R7: end of the last chip stops the request.
  task automatic t_last_chip;
    start_req(24'h3FFFFC, 16'd20, 4'd3);
    do_chunk(4'd3, 20'hFFFFC, 16'd4, 1'b0, 0, 1'b0, 4'd0);
    check_done(1'b0, 4'd0, 16'd4);
  endtask

  // R9: engine error aborts.
  task automatic t_error;
    start_req(24'h200000, 16'd64, 4'd4);
    do_chunk(4'd2, 20'h00000, 16'd16, 1'b0, 0, 1'b0, 4'd0);
    do_chunk(4'd2, 20'h00010, 16'd16, 1'b0, 0, 1'b1, 4'd5);
    check_done(1'b1, 4'd5, 16'd16);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_empty();
    t_head_buffered();
    t_head_cap();
    t_chip_step();
    t_last_chip();
    t_error();
    t_head_buffered();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule